// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects every interrupt request that can reach a small processor core and tells the core where to jump. The sources are a hardware-reset request, four internal exceptions, a non-maskable request, two external request pins and a parameterised set of peripheral request lines. Each source owns one two-word slot in the first 64 words of program memory. In any cycle the controller looks at all pending requests that the core's current mask level allows. It picks one of them and raises a request strobe with that slot's vector address and priority level.

The core answers with a one-cycle acknowledge when it starts fetching from the vector. The controller then drops the strobe, retires an edge-type request if it held one, and arbitrates again on the next cycle. Each external pin has its own enable bit, priority level and detection mode. Each peripheral line has its own priority level.

Top module: `vec_int_ctrl`

## Requirements
- R1: The vector address is twice the slot number. The slots are: reset 0 (0x00), stack error 1 (0x02), trace 2 (0x04), software interrupt 3 (0x06), pin 0 slot 4 (0x08), pin 1 slot 5 (0x0A), non-maskable 15 (0x1E) and illegal instruction 31 (0x3E). Peripheral line j (j < 9) uses slot 6+j. Peripheral line j (j >= 9) uses slot 7+j.
- R2: Reset, stack error, trace, software interrupt, non-maskable and illegal instruction requests are granted at level 3, whatever the mask level.
- R3: The reset request is level-sensitive and beats every other request. While it is held, it is granted again after each acknowledge.
- R4: A request at level 0, 1 or 2 is granted only while its level is greater than or equal to `mask_lvl`. A masked request stays pending and is granted once the mask allows it.
- R5: Among the eligible requests the highest level wins. Among those of equal level the lowest vector address wins.
- R6: Pin k is configured by `ext_cfg[4k+3]` (enable), `ext_cfg[4k+2]` (1 = edge mode, 0 = level mode) and `ext_cfg[4k+1:4k]` (level). Level code 3 means no request. A disabled pin, or a pin with level code 3, never requests and latches no edge. The same level code 3 on a peripheral line means no request.
- R7: In edge mode, a rising edge on a pin stays pending until its vector is acknowledged. In level mode, and for peripheral lines, a request stands only while the line is high.
- R8: A one-cycle pulse on stack error, trace, software interrupt, non-maskable or illegal instruction stays pending until that vector is acknowledged.
- R9: From the rise of `irq_out` until `core_ack`, `vec_addr` and `grant_lvl` hold still. `irq_out` is low in the cycle after the acknowledge. An acknowledge while `irq_out` is low has no effect.
- R10: A new rising edge on an edge-mode pin in the same cycle as the acknowledge of that pin's vector leaves the pin pending, so it is granted again.
- R11: After reset `irq_out`, `vec_addr` and `grant_lvl` are all 0.
- R12: A request sampled at clock edge n, with the controller idle, shows on `irq_out` after edge n+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_reset | input | 1 | Hardware-reset request (level) |
| exc_stack | input | 1 | Stack-error exception pulse |
| exc_trace | input | 1 | Trace exception pulse |
| exc_swi | input | 1 | Software-interrupt pulse |
| exc_nmi | input | 1 | Non-maskable request pulse |
| exc_illegal | input | 1 | Illegal-instruction pulse |
| ext_req | input | 2 | External request pins |
| ext_cfg | input | 8 | Per-pin enable, mode and level (4 bits per pin) |
| per_req | input | NUM_PERIPH | Peripheral request lines (level) |
| per_lvl | input | 2*NUM_PERIPH | Peripheral levels, 2 bits per line, 3 = none |
| mask_lvl | input | 2 | Core's current interrupt mask level |
| core_ack | input | 1 | Core accepts the presented vector |
| irq_out | output | 1 | Interrupt request strobe to the core |
| vec_addr | output | 6 | Program-word address of the granted vector |
| grant_lvl | output | 2 | Priority level of the granted request |

## Verification
Two events can land in the same clock edge: the core acknowledges a pin's vector, and a new rising edge arrives on that same pin. The set of the pending bit then competes with its clear. The bench provokes this by driving the pin high again in the very cycle it drives `core_ack`. It judges the outcome at the ports: `irq_out` must drop for one cycle and then rise again with the same vector, and after the second acknowledge it must stay low. A second overlap is a higher-priority pulse arriving while a grant is held. The bench checks that the held vector does not move, and that the newcomer is presented right after the acknowledge.

// File: rtl/vic_pkg.sv
// Package vic_pkg
// Shared constants for the vectored interrupt controller: slot numbering,
// level encodings and the peripheral-to-slot mapping.
// Assumes 32 two-word slots, so a vector address is 6 bits wide.
package vic_pkg;

    localparam int SLOT_W   = 5;
    localparam int NSLOT    = 1 << SLOT_W;
    localparam int VEC_W    = SLOT_W + 1;
    localparam int LVL_W    = 2;
    localparam int NEXC     = 5;
    localparam int NPIN     = 2;
    localparam int PCFG_W   = 4;
    localparam int MAX_PERIPH = 24;

    localparam logic [LVL_W-1:0] LVL_FIXED = 2'd3;
    localparam logic [LVL_W-1:0] LVL_NONE  = 2'd3;

    localparam int SLOT_RESET = 0;
    localparam int SLOT_PIN0  = 4;

    // Latched exceptions: stack error, trace, software, non-maskable, illegal
    localparam logic [SLOT_W-1:0] EXC_SLOTS [NEXC] = '{5'd1, 5'd2, 5'd3, 5'd15, 5'd31};

    localparam int PER_LO_BASE = 6;
    localparam int PER_LO_CNT  = 9;
    localparam int PER_HI_BASE = 16;

    // Slot of peripheral line j: fills the free slots below and above slot 15
    function automatic logic [SLOT_W-1:0] periph_slot(input int j);
        if (j < PER_LO_CNT)
            return SLOT_W'(PER_LO_BASE + j);
        return SLOT_W'(PER_HI_BASE + j - PER_LO_CNT);
    endfunction

endpackage

// File: rtl/vic_sticky.sv
// Module vic_sticky
// Pending latch for a pulsed exception: set by the request, cleared when the
// core acknowledges the matching vector. A set in the same cycle wins.
// Assumes the request is synchronous to clk.
module vic_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Hold the pending state between the pulse and its acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    // R8
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/vic_pin.sv
// Module vic_pin
// Conditions one external request pin according to its 4-bit control field
// {enable, edge_mode, level[1:0]}. In edge mode a rising edge is latched
// until the vector is acknowledged; in level mode the sampled pin is the
// request. A disarmed pin (disabled, or level code 3) holds nothing.
// Assumes the pin is already synchronous to clk.
module vic_pin
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic [PCFG_W-1:0] cfg_i,
    input  logic              clr_i,
    output logic              req_o,
    output logic [LVL_W-1:0]  lvl_o
);

    logic pin_q;
    logic pend_q;
    logic armed;
    logic edge_mode;
    logic rise;

    assign armed     = cfg_i[3] && (cfg_i[1:0] != LVL_NONE);
    assign edge_mode = cfg_i[2];
    assign rise      = pin_i && !pin_q;

    // Sample the pin once: the sample is both the level request and edge history
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= 1'b0;
        else
            pin_q <= pin_i;
    end

    // Edge latch; cleared whenever the pin is not armed for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (!(armed && edge_mode))
            pend_q <= 1'b0;
        else if (rise)
            pend_q <= 1'b1;
        else if (clr_i)
            pend_q <= 1'b0;
    end

    assign req_o = armed && (edge_mode ? pend_q : pin_q);
    assign lvl_o = cfg_i[1:0];

    // R7
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && edge_mode && rise && $stable(cfg_i)) |=> req_o);

    // R6
    disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i[3] && $stable(cfg_i)) |-> !req_o);

endmodule

// File: rtl/vic_arbiter.sv
// Module vic_arbiter
// Combinational selection among the slot requests: keeps those whose level
// is fixed or at least the mask, takes the highest level present, and inside
// that level the lowest slot number.
// Assumes one request bit and one 2-bit level per slot.
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NSRC = NSLOT
) (
    input  logic [NSRC-1:0]       req_i,
    input  logic [NSRC*LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0]      mask_i,
    output logic                  win_valid_o,
    output logic [SLOT_W-1:0]     win_slot_o,
    output logic [LVL_W-1:0]      win_lvl_o
);

    localparam int NLVL = 1 << LVL_W;

    logic [NSRC-1:0]   elig;
    logic [NSRC-1:0]   bucket [NLVL];
    logic              any_at [NLVL];
    logic [SLOT_W-1:0] first_at [NLVL];

    // Eligibility of each slot against the mask
    for (genvar i = 0; i < NSRC; i++) begin : g_elig
        assign elig[i] = req_i[i] &&
            ((lvl_i[i*LVL_W +: LVL_W] == LVL_FIXED) ||
             (lvl_i[i*LVL_W +: LVL_W] >= mask_i));
    end

    // Per-level bucket and lowest-slot encoder
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        for (genvar i = 0; i < NSRC; i++) begin : g_bk
            assign bucket[l][i] = elig[i] && (lvl_i[i*LVL_W +: LVL_W] == LVL_W'(l));
        end

        // Lowest set slot in this level's bucket
        always_comb begin
            any_at[l]   = |bucket[l];
            first_at[l] = '0;
            for (int i = NSRC - 1; i >= 0; i--) begin
                if (bucket[l][i])
                    first_at[l] = SLOT_W'(i);
            end
        end
    end

    // Highest non-empty level overrides lower ones
    always_comb begin
        win_valid_o = 1'b0;
        win_slot_o  = '0;
        win_lvl_o   = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (any_at[l]) begin
                win_valid_o = 1'b1;
                win_slot_o  = first_at[l];
                win_lvl_o   = LVL_W'(l);
            end
        end
    end

endmodule

// File: rtl/vic_grant.sv
// Module vic_grant
// Request/acknowledge handshake toward the core: captures the arbiter's winner
// when idle, holds slot and level until the acknowledge, and reports the
// acknowledged slot for one cycle so its pending latch can be cleared.
// Assumes the acknowledge is a single-cycle pulse.
module vic_grant
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_valid_i,
    input  logic [SLOT_W-1:0] win_slot_i,
    input  logic [LVL_W-1:0]  win_lvl_i,
    input  logic              ack_i,
    output logic              irq_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [LVL_W-1:0]  lvl_o,
    output logic              retire_o
);

    // Capture the winner when idle, release the strobe on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            slot_o <= '0;
            lvl_o  <= '0;
        end else if (!irq_o && win_valid_i) begin
            irq_o  <= 1'b1;
            slot_o <= win_slot_i;
            lvl_o  <= win_lvl_i;
        end else if (irq_o && ack_i) begin
            irq_o  <= 1'b0;
        end
    end

    assign retire_o = irq_o && ack_i;

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> (irq_o && $stable(slot_o) && $stable(lvl_o)));

    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

endmodule

// File: rtl/vec_int_ctrl.sv
// Module vec_int_ctrl
// Vectored priority interrupt controller. Conditions every source into a
// per-slot request and level, arbitrates against the core's mask, and
// presents the winner's vector address until the core acknowledges it.
// Assumes all inputs are synchronous to clk and core_ack is one cycle long.
module vec_int_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_PERIPH = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        exc_reset,
    input  logic                        exc_stack,
    input  logic                        exc_trace,
    input  logic                        exc_swi,
    input  logic                        exc_nmi,
    input  logic                        exc_illegal,
    input  logic [NPIN-1:0]             ext_req,
    input  logic [NPIN*PCFG_W-1:0]      ext_cfg,
    input  logic [NUM_PERIPH-1:0]       per_req,
    input  logic [NUM_PERIPH*LVL_W-1:0] per_lvl,
    input  logic [LVL_W-1:0]            mask_lvl,
    input  logic                        core_ack,
    output logic                        irq_out,
    output logic [VEC_W-1:0]            vec_addr,
    output logic [LVL_W-1:0]            grant_lvl
);

    logic                   rst_req_q;
    logic [NEXC-1:0]        exc_in;
    logic [NEXC-1:0]        exc_pend;
    logic [NPIN-1:0]        pin_req;
    logic [LVL_W-1:0]       pin_lvl [NPIN];
    logic [NUM_PERIPH-1:0]  per_q;
    logic [NSLOT-1:0]       req_vec;
    logic [NSLOT*LVL_W-1:0] lvl_vec;
    logic [NSLOT-1:0]       clr_vec;
    logic                   win_valid;
    logic [SLOT_W-1:0]      win_slot;
    logic [LVL_W-1:0]       win_lvl;
    logic [SLOT_W-1:0]      held_slot;
    logic                   retire;

    assign exc_in = {exc_illegal, exc_nmi, exc_swi, exc_trace, exc_stack};

    // Sample the level-type inputs so every source reaches arbitration together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
            per_q     <= '0;
        end else begin
            rst_req_q <= exc_reset;
            per_q     <= per_req;
        end
    end

    // Decode the acknowledged slot into per-slot clear strobes
    always_comb begin
        for (int s = 0; s < NSLOT; s++)
            clr_vec[s] = retire && (held_slot == SLOT_W'(s));
    end

    for (genvar k = 0; k < NEXC; k++) begin : g_exc
        vic_sticky u_sticky (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (exc_in[k]),
            .clr_i (clr_vec[EXC_SLOTS[k]]),
            .q_o   (exc_pend[k])
        );
    end

    for (genvar k = 0; k < NPIN; k++) begin : g_pin
        vic_pin u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (ext_req[k]),
            .cfg_i (ext_cfg[k*PCFG_W +: PCFG_W]),
            .clr_i (clr_vec[SLOT_PIN0 + k]),
            .req_o (pin_req[k]),
            .lvl_o (pin_lvl[k])
        );
    end

    // Gather every source into its slot's request bit and level
    always_comb begin
        req_vec = '0;
        lvl_vec = '0;
        req_vec[SLOT_RESET] = rst_req_q;
        lvl_vec[SLOT_RESET*LVL_W +: LVL_W] = LVL_FIXED;
        for (int k = 0; k < NEXC; k++) begin
            req_vec[EXC_SLOTS[k]] = exc_pend[k];
            lvl_vec[int'(EXC_SLOTS[k])*LVL_W +: LVL_W] = LVL_FIXED;
        end
        for (int k = 0; k < NPIN; k++) begin
            req_vec[SLOT_PIN0 + k] = pin_req[k];
            lvl_vec[(SLOT_PIN0 + k)*LVL_W +: LVL_W] = pin_lvl[k];
        end
        for (int j = 0; j < NUM_PERIPH; j++) begin
            req_vec[periph_slot(j)] = per_q[j] && (per_lvl[j*LVL_W +: LVL_W] != LVL_NONE);
            lvl_vec[int'(periph_slot(j))*LVL_W +: LVL_W] = per_lvl[j*LVL_W +: LVL_W];
        end
    end

    vic_arbiter #(
        .NSRC (NSLOT)
    ) u_arb (
        .req_i       (req_vec),
        .lvl_i       (lvl_vec),
        .mask_i      (mask_lvl),
        .win_valid_o (win_valid),
        .win_slot_o  (win_slot),
        .win_lvl_o   (win_lvl)
    );

    vic_grant u_grant (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_valid_i (win_valid),
        .win_slot_i  (win_slot),
        .win_lvl_i   (win_lvl),
        .ack_i       (core_ack),
        .irq_o       (irq_out),
        .slot_o      (held_slot),
        .lvl_o       (grant_lvl),
        .retire_o    (retire)
    );

    assign vec_addr = {held_slot, 1'b0};

    // R4
    mask_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> ((grant_lvl == LVL_FIXED) || (grant_lvl >= $past(mask_lvl))));

    // R3
    reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_out) && $past(rst_req_q)) |-> (vec_addr == '0));

endmodule

// File: tb/vec_int_ctrl_tb.sv
module vec_int_ctrl_tb;

    localparam int NP = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exc_reset = 0, exc_stack = 0, exc_trace = 0, exc_swi = 0;
    logic          exc_nmi = 0, exc_illegal = 0;
    logic [1:0]    ext_req = '0;
    logic [7:0]    ext_cfg = '0;
    logic [NP-1:0] per_req = '0;
    logic [2*NP-1:0] per_lvl = '1;
    logic [1:0]    mask_lvl = '0;
    logic          core_ack = 1'b0;
    logic          irq_out;
    logic [5:0]    vec_addr;
    logic [1:0]    grant_lvl;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vec_int_ctrl #(.NUM_PERIPH(NP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .exc_reset(exc_reset), .exc_stack(exc_stack), .exc_trace(exc_trace),
        .exc_swi(exc_swi), .exc_nmi(exc_nmi), .exc_illegal(exc_illegal),
        .ext_req(ext_req), .ext_cfg(ext_cfg), .per_req(per_req), .per_lvl(per_lvl),
        .mask_lvl(mask_lvl), .core_ack(core_ack),
        .irq_out(irq_out), .vec_addr(vec_addr), .grant_lvl(grant_lvl)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Peripheral j slot per R1
    function automatic int pslot(input int j);
        return (j < 9) ? 6 + j : 7 + j;
    endfunction

    // Level of a slot as the requirements define it
    function automatic int slot_lvl(input int s);
        if (s == 0 || s == 1 || s == 2 || s == 3 || s == 15 || s == 31) return 3;
        if (s == 4) return int'(ext_cfg[1:0]);
        if (s == 5) return int'(ext_cfg[5:4]);
        for (int j = 0; j < NP; j++)
            if (pslot(j) == s) return int'(per_lvl[2*j +: 2]);
        return 3;
    endfunction

    // Expected winner: {valid, slot}
    function automatic logic [5:0] pick(input logic [31:0] pend, input logic [1:0] msk);
        int best = -1;
        int bl = -1;
        for (int s = 0; s < 32; s++) begin
            if (pend[s]) begin
                int l = slot_lvl(s);
                if ((l == 3 || l >= int'(msk)) && l > bl) begin
                    best = s;
                    bl = l;
                end
            end
        end
        if (best < 0) return 6'd0;
        return {1'b1, 5'(best)};
    endfunction

    function automatic bit pin_armed(input int k);
        return ext_cfg[4*k+3] && (ext_cfg[4*k +: 2] != 2'd3);
    endfunction

    task automatic wait_irq(output bit got);
        got = 0;
        for (int i = 0; i < 20; i++) begin
            if (irq_out) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic do_ack();
        core_ack = 1'b1;
        @(negedge clk);
        core_ack = 1'b0;
    endtask

    task automatic expect_grant(input string tag, input int slot, input int lvl);
        bit got;
        wait_irq(got);
        check({tag, " irq"}, int'(got), 1);
        check({tag, " vec"}, int'(vec_addr), slot * 2);
        check({tag, " lvl"}, int'(grant_lvl), lvl);
    endtask

    task automatic expect_quiet(input string tag);
        repeat (3) @(negedge clk);
        check({tag, " quiet"}, int'(irq_out), 0);
    endtask

    task automatic drain(inout logic [31:0] e, input string tag);
        logic [5:0] w;
        while (1) begin
            w = pick(e, mask_lvl);
            if (!w[5]) break;
            expect_grant(tag, int'(w[4:0]), slot_lvl(int'(w[4:0])));
            do_ack();
            e[w[4:0]] = 1'b0;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        bit got;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 irq", int'(irq_out), 0);
        check("R11 vec", int'(vec_addr), 0);
        check("R11 lvl", int'(grant_lvl), 0);

        // R12 latency, R2 level 3 through full mask, R1 address
        mask_lvl = 2'd3;
        exc_nmi = 1'b1;
        @(negedge clk);
        exc_nmi = 1'b0;
        check("R12 not early", int'(irq_out), 0);
        @(negedge clk);
        check("R12 on time", int'(irq_out), 1);
        check("R1 nmi vec", int'(vec_addr), 8'h1E);
        check("R2 nmi lvl", int'(grant_lvl), 3);
        do_ack();
        expect_quiet("R8 nmi retired");

        // R3 reset wins and re-requests; R5 level beats address
        mask_lvl = 2'd0;
        ext_cfg = 8'h0A;
        ext_req = 2'b01;
        exc_reset = 1'b1;
        exc_illegal = 1'b1;
        @(negedge clk);
        exc_illegal = 1'b0;
        expect_grant("R3 reset first", 0, 3);
        do_ack();
        expect_grant("R3 reset again", 0, 3);
        exc_reset = 1'b0;
        do_ack();
        expect_grant("R5 illegal over pin", 31, 3);
        do_ack();
        expect_grant("R7 level pin", 4, 2);
        ext_req = 2'b00;
        do_ack();
        expect_quiet("R7 level pin dropped");

        // R9 held vector stays while a higher source arrives
        ext_cfg = 8'hD0;
        ext_req = 2'b10;
        @(negedge clk);
        ext_req = 2'b00;
        expect_grant("R9 pin1", 5, 1);
        exc_nmi = 1'b1;
        @(negedge clk);
        exc_nmi = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 still held irq", int'(irq_out), 1);
        check("R9 still held vec", int'(vec_addr), 8'h0A);
        do_ack();
        check("R9 drop after ack", int'(irq_out), 0);
        expect_grant("R9 nmi next", 15, 3);
        do_ack();
        expect_quiet("R7 pin1 edge retired");

        // R9 stray acknowledge has no effect
        core_ack = 1'b1;
        @(negedge clk);
        core_ack = 1'b0;
        expect_quiet("R9 stray ack");
        exc_swi = 1'b1;
        @(negedge clk);
        exc_swi = 1'b0;
        expect_grant("R9 after stray ack swi", 3, 3);
        do_ack();

        // R10 new edge in the acknowledge cycle
        ext_cfg = 8'h0E;
        ext_req = 2'b01;
        @(negedge clk);
        ext_req = 2'b00;
        expect_grant("R10 first", 4, 2);
        core_ack = 1'b1;
        ext_req = 2'b01;
        @(negedge clk);
        core_ack = 1'b0;
        ext_req = 2'b00;
        check("R10 gap", int'(irq_out), 0);
        expect_grant("R10 again", 4, 2);
        do_ack();
        expect_quiet("R10 retired");

        // R6 disabled pin latches nothing; level code 3 never requests
        ext_cfg = 8'h06;
        ext_req = 2'b01;
        @(negedge clk);
        ext_req = 2'b00;
        expect_quiet("R6 disabled");
        ext_cfg = 8'h0E;
        expect_quiet("R6 no latched edge");
        ext_cfg = 8'h0B;
        ext_req = 2'b01;
        expect_quiet("R6 level code 3");
        ext_req = 2'b00;

        // R4 masked level request waits for the mask
        ext_cfg = 8'h90;
        mask_lvl = 2'd2;
        ext_req = 2'b10;
        expect_quiet("R4 masked");
        mask_lvl = 2'd1;
        expect_grant("R4 unmasked", 5, 1);
        ext_req = 2'b00;
        do_ack();
        expect_quiet("R4 done");

        // Random mixes: R1 R4 R5 R7 R8
        for (int it = 0; it < 80; it++) begin
            logic [31:0] e;
            logic [31:0] lv;
            logic [5:0] w;
            e = '0;
            lv = '0;
            ext_cfg = 8'($urandom);
            per_lvl = (2*NP)'($urandom);
            mask_lvl = 2'($urandom);
            @(negedge clk);
            exc_stack   = ($urandom % 4) == 0;
            exc_trace   = ($urandom % 4) == 0;
            exc_swi     = ($urandom % 4) == 0;
            exc_nmi     = ($urandom % 6) == 0;
            exc_illegal = ($urandom % 6) == 0;
            exc_reset   = ($urandom % 10) == 0;
            ext_req = 2'($urandom);
            per_req = NP'($urandom);
            e[1] = exc_stack; e[2] = exc_trace; e[3] = exc_swi;
            e[15] = exc_nmi; e[31] = exc_illegal;
            lv[0] = exc_reset;
            for (int k = 0; k < 2; k++) begin
                if (pin_armed(k) && ext_req[k]) begin
                    if (ext_cfg[4*k+2]) e[4+k] = 1'b1;
                    else lv[4+k] = 1'b1;
                end
            end
            for (int j = 0; j < NP; j++)
                if (per_req[j] && per_lvl[2*j +: 2] != 2'd3) lv[pslot(j)] = 1'b1;
            @(negedge clk);
            {exc_stack, exc_trace, exc_swi, exc_nmi, exc_illegal} = '0;
            w = pick(e | lv, mask_lvl);
            if (w[5]) begin
                expect_grant("R5 random first", int'(w[4:0]), slot_lvl(int'(w[4:0])));
                ext_req = '0; per_req = '0; exc_reset = 1'b0;
                do_ack();
                e[w[4:0]] = 1'b0;
            end else begin
                expect_quiet("R4 random none");
                ext_req = '0; per_req = '0; exc_reset = 1'b0;
            end
            drain(e, "R8 random drain");
            expect_quiet("R4 random masked remain");
            mask_lvl = 2'd0;
            drain(e, "R4 random unmasked");
            expect_quiet("R7 random empty");
        end

        report();
        $finish;
    end

endmodule